// File: doc/BRIEF.md
# Watchdog Timer with Write-Protected Control Register

This block supervises software. Once the enable field is set, a 16-bit counter advances on each pulse of a 32.768 kHz tick enable. If software does not rewrite the enable bit with a 1 before the selected period ends, the block acts. In reset mode it issues a one-cycle system reset request. In interrupt mode it issues a one-cycle interrupt request. A sticky timeout flag records the event, and that flag survives the block's own reset.

Software must unlock the 8-bit control register before each change. A bus write with bit 0 set arms the register, and the very next retired instruction has to be a control write, which is then applied. When the next retired instruction is anything else, the arming is cancelled. An unlock state machine has two states. In `UNL_LOCKED` the ARM transition moves to `UNL_ARMED`. In `UNL_ARMED` the COMMIT transition (a control write) and the CANCEL transition (a retire without a write) both return to `UNL_LOCKED`. A FORCE transition returns to `UNL_LOCKED` whenever the watchdog resets the register. The block also accepts an external hardware reset and a power-supply-monitor event.

Top module: `wdt_ctrl`

## Requirements
- R1: After hardware reset the control register reads 0x10, and both the reset request and the interrupt request are low. The register fields are: bits 7:4 period code, bit 3 interrupt mode, bit 2 timeout flag, bit 1 enable, bit 0 unlock.
- R2: When the register is not armed, a write with bit 0 = 0 changes nothing. A write with bit 0 = 1 sets only the unlock bit, which then reads back as 1.
- R3: When the register is armed, the next control write loads bits 7:3 and bit 1 from the write data, and the unlock bit reads back as 0 afterwards.
- R4: When the register is armed, a retire pulse without a control write cancels the arming, and later writes are then treated as in R2.
- R5: When the period code c is in 0..7, the counter counts only tick pulses seen while enabled. The timeout action fires on the tick that makes 2^(c+9) ticks since the last write of enable = 1, and that write clears the counter.
- R6: In reset mode (bit 3 = 0), a timeout gives a one-cycle reset request. The register becomes 0x14: reset value, unlock bit cleared, timeout flag set.
- R7: In interrupt mode (bit 3 = 1), a timeout gives a one-cycle interrupt request and sets the timeout flag. The enable bit stays set, and the counter restarts from zero.
- R8: A committed write with bit 2 = 0 clears the timeout flag. A committed write with bit 2 = 1 does not set it. Hardware reset clears it.
- R9: When the period code is 8 and the block is enabled, a reset request is issued on the next cycle in either mode.
- R10: Period codes 9 to 15 never cause a timeout.
- R11: A power-supply-monitor event clears the enable bit. While the block is disabled the counter does not advance.
- R12: When a timeout and a committed write fall in the same cycle, a reset-mode timeout overrides the write. An interrupt-mode timeout sets the flag even if the write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| tick | input | 1 | 32.768 kHz count enable, one cycle wide |
| retire | input | 1 | An instruction retired this cycle |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Write data |
| psm_evt | input | 1 | Power-supply-monitor event |
| ctl_rdata | output | 8 | Control register read value |
| wd_rst_req | output | 1 | One-cycle system reset request |
| wd_irq | output | 1 | One-cycle high-priority interrupt request |

## Verification
The sharpest collision is a timeout that expires on the same clock edge as the committed half of an unlock sequence. The bench provokes it by counting cycles from the enabling write and placing the arming write and the commit on the last two ticks of the period. For a reset-mode timeout it checks that the register reads 0x14 rather than the written value. For an interrupt-mode timeout it checks that the timeout flag reads 1 even though the write cleared it. A behavioural reference model runs beside the design, and the bench compares the two on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int PRE_W = 4;

    typedef enum logic {
        UNL_LOCKED = 1'b0,
        UNL_ARMED  = 1'b1
    } unl_state_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             irq_mode;
        logic             status;
        logic             en;
        logic             unl;
    } wdt_ctl_t;

    localparam logic [PRE_W-1:0] RST_PRE = 4'h1;

endpackage

// File: rtl/wdt_unlock_fsm.sv
module wdt_unlock_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic force_lock,
    input  logic wr,
    input  logic wr_bit0,
    input  logic retire,
    output logic armed,
    output logic commit
);

    unl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UNL_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UNL_LOCKED: begin
                if (!force_lock && wr && wr_bit0) state_d = UNL_ARMED;     // ARM
            end
            UNL_ARMED: begin
                if (force_lock)   state_d = UNL_LOCKED;                    // FORCE
                else if (wr)      state_d = UNL_LOCKED;                    // COMMIT
                else if (retire)  state_d = UNL_LOCKED;                    // CANCEL
            end
            default: state_d = UNL_LOCKED;
        endcase
    end

    always_comb begin
        armed  = (state_q == UNL_ARMED);
        commit = (state_q == UNL_ARMED) && wr;
    end

endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRE_BASE = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] pre,
    input  logic             tick,
    input  logic             clear,
    output logic             expire,
    output logic             imm
);

    localparam logic [PRE_W-1:0] MAX_CODE = PRE_W'(CNT_W - PRE_BASE);
    localparam logic [PRE_W-1:0] IMM_CODE = PRE_W'(CNT_W - PRE_BASE + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   last;
    logic             code_ok;
    logic             tmo;

    always_comb begin
        span    = (CNT_W+1)'(1) << (PRE_BASE + int'(pre));
        last    = span - (CNT_W+1)'(1);
        code_ok = (pre <= MAX_CODE);
        tmo     = en && tick && code_ok && (cnt_q == last[CNT_W-1:0]);
        imm     = en && (pre == IMM_CODE);
        expire  = tmo || imm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clear)      cnt_q <= '0;
        else if (en && tick) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRE_BASE = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       retire,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       psm_evt,
    output logic [7:0] ctl_rdata,
    output logic       wd_rst_req,
    output logic       wd_irq
);

    wdt_ctl_t         wr_f, rd_f;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic             mode_q, mode_d, stat_q, stat_d, en_q, en_d;
    logic             armed, commit, expire, imm;
    logic             exp_rst, exp_irq, cnt_clr;
    logic             rst_q, irq_q;

    assign wr_f    = wdt_ctl_t'(ctl_wdata);
    assign exp_rst = expire && (imm || !mode_q);
    assign exp_irq = expire && !imm && mode_q;
    assign cnt_clr = expire || (commit && wr_f.en);

    wdt_unlock_fsm u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_lock (exp_rst),
        .wr         (ctl_wr),
        .wr_bit0    (wr_f.unl),
        .retire     (retire),
        .armed      (armed),
        .commit     (commit)
    );

    wdt_timeout #(.CNT_W(CNT_W), .PRE_BASE(PRE_BASE)) u_timeout (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_q),
        .pre    (pre_q),
        .tick   (tick),
        .clear  (cnt_clr),
        .expire (expire),
        .imm    (imm)
    );

    always_comb begin
        pre_d  = pre_q;
        mode_d = mode_q;
        stat_d = stat_q;
        en_d   = en_q;
        if (exp_rst) begin
            pre_d  = RST_PRE;
            mode_d = 1'b0;
            stat_d = 1'b1;
            en_d   = 1'b0;
        end else begin
            if (commit) begin
                pre_d  = wr_f.pre;
                mode_d = wr_f.irq_mode;
                stat_d = stat_q && wr_f.status;
                en_d   = wr_f.en;
            end
            if (exp_irq) stat_d = 1'b1;
            if (psm_evt) en_d   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= RST_PRE;
            mode_q <= 1'b0;
            stat_q <= 1'b0;
            en_q   <= 1'b0;
            rst_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            pre_q  <= pre_d;
            mode_q <= mode_d;
            stat_q <= stat_d;
            en_q   <= en_d;
            rst_q  <= exp_rst;
            irq_q  <= exp_irq;
        end
    end

    always_comb begin
        rd_f.pre      = pre_q;
        rd_f.irq_mode = mode_q;
        rd_f.status   = stat_q;
        rd_f.en       = en_q;
        rd_f.unl      = armed;
    end

    assign ctl_rdata  = rd_f;
    assign wd_rst_req = rst_q;
    assign wd_irq     = irq_q;

endmodule

// File: rtl/wdt_ctrl_chk.sv
module wdt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [7:0] ctl_wdata,
    input logic       psm_evt,
    input logic [7:0] ctl_rdata,
    input logic       wd_rst_req,
    input logic       wd_irq
);

    p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |=> !wd_rst_req);

    p_rst_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> (ctl_rdata == 8'h14));

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |=> !wd_irq);

    p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> ctl_rdata[2]);

    p_one_action_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wd_irq && wd_rst_req));

    p_locked_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_rdata[0] && !ctl_wdata[0] && !psm_evt)
        |=> (wd_irq || wd_rst_req || $stable(ctl_rdata[7:1])));

    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_rdata[0] && ctl_wdata[0]) |=> (ctl_rdata[0] || wd_rst_req));

    p_commit_unl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_rdata[0]) |=> !ctl_rdata[0]);

endmodule

bind wdt_ctrl wdt_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .psm_evt    (psm_evt),
    .ctl_rdata  (ctl_rdata),
    .wd_rst_req (wd_rst_req),
    .wd_irq     (wd_irq)
);

// File: tb/wdt_ctrl_tb.sv
`timescale 1ns/1ps
module wdt_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       retire = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       psm_evt = 1'b0;
    logic [7:0] ctl_rdata;
    logic       wd_rst_req, wd_irq;

    int    errors = 0;
    int    checks = 0;
    string phase  = "R1";

    always #2 clk = ~clk;

    wdt_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .retire     (retire),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .psm_evt    (psm_evt),
        .ctl_rdata  (ctl_rdata),
        .wd_rst_req (wd_rst_req),
        .wd_irq     (wd_irq)
    );

    // behavioural reference model
    int m_pre, m_cnt;
    bit m_mode, m_stat, m_en, m_arm, m_rst, m_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 1; m_mode = 0; m_stat = 0; m_en = 0; m_arm = 0;
            m_cnt = 0; m_rst = 0; m_irq = 0;
        end else begin
            bit imm, tmo, er, ei, com, narm;
            int ncnt;
            imm  = m_en && (m_pre == 8);
            tmo  = m_en && tick && (m_pre <= 7) && (m_cnt == (1 << (m_pre + 9)) - 1);
            er   = (imm || tmo) && (imm || !m_mode);
            ei   = (imm || tmo) && !er;
            com  = m_arm && ctl_wr;
            if (er)         narm = 0;
            else if (m_arm) narm = !(ctl_wr || retire);
            else            narm = ctl_wr && ctl_wdata[0];
            if (imm || tmo || (com && ctl_wdata[1])) ncnt = 0;
            else if (m_en && tick)                   ncnt = (m_cnt + 1) % 65536;
            else                                     ncnt = m_cnt;
            if (er) begin
                m_pre = 1; m_mode = 0; m_stat = 1; m_en = 0;
            end else begin
                if (com) begin
                    m_pre  = int'(ctl_wdata[7:4]);
                    m_mode = ctl_wdata[3];
                    m_stat = m_stat && ctl_wdata[2];
                    m_en   = ctl_wdata[1];
                end
                if (ei) m_stat = 1;
                if (psm_evt) m_en = 0;
            end
            m_arm = narm; m_cnt = ncnt; m_rst = er; m_irq = ei;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(phase, int'(ctl_rdata),
                (m_pre << 4) | (int'(m_mode) << 3) | (int'(m_stat) << 2) | (int'(m_en) << 1) | int'(m_arm));
            chk(phase, int'(wd_rst_req), int'(m_rst));
            chk(phase, int'(wd_irq), int'(m_irq));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] d);
        ctl_wr = 1'b1; retire = 1'b1; ctl_wdata = d;
        step();
        ctl_wr = 1'b0; retire = 1'b0;
    endtask

    task automatic prot_wr(input logic [7:0] d);
        wr(8'h01);
        wr(d);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", int'(ctl_rdata), 8'h10);
        chk("R1", int'(wd_rst_req), 0);
        chk("R1", int'(wd_irq), 0);
        tick = 1'b1;

        // R2 locked writes
        phase = "R2";
        wr(8'hF6);
        chk("R2", int'(ctl_rdata), 8'h10);
        wr(8'h01);
        chk("R2", int'(ctl_rdata), 8'h11);

        // R4 cancel by an unrelated retire
        phase = "R4";
        retire = 1'b1; step(); retire = 1'b0;
        chk("R4", int'(ctl_rdata), 8'h10);
        wr(8'h3A);
        chk("R4", int'(ctl_rdata), 8'h10);

        // R3 accepted write
        phase = "R3";
        prot_wr(8'h38);
        chk("R3", int'(ctl_rdata), 8'h38);
        prot_wr(8'h10);
        chk("R3", int'(ctl_rdata), 8'h10);

        // R5 / R6 reset-mode timeout, code 0 -> 512 ticks
        phase = "R5";
        prot_wr(8'h02);
        repeat (511) step();
        chk("R5", int'(wd_rst_req), 0);
        step();
        chk("R6", int'(wd_rst_req), 1);
        chk("R6", int'(ctl_rdata), 8'h14);
        step();
        chk("R6", int'(wd_rst_req), 0);

        // R5 ticks on alternate cycles only
        phase = "R5";
        tick = 1'b0;
        prot_wr(8'h02);
        for (int i = 0; i < 1100; i++) begin
            tick = i[0];
            step();
        end
        tick = 1'b1;

        // R7 interrupt-mode timeout, repeated
        phase = "R7";
        prot_wr(8'h0A);
        chk("R7", int'(ctl_rdata), 8'h0A);
        repeat (511) step();
        chk("R7", int'(wd_irq), 0);
        step();
        chk("R7", int'(wd_irq), 1);
        chk("R7", int'(ctl_rdata), 8'h0E);
        repeat (511) step();
        chk("R7", int'(wd_irq), 0);
        step();
        chk("R7", int'(wd_irq), 1);

        // R8 flag clear, no software set, hardware reset clears
        phase = "R8";
        prot_wr(8'h0A);
        chk("R8", int'(ctl_rdata), 8'h0A);
        prot_wr(8'h0E);
        chk("R8", int'(ctl_rdata), 8'h0A);
        repeat (600) step();
        chk("R8", int'(ctl_rdata), 8'h0E);
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        chk("R8", int'(ctl_rdata), 8'h10);

        // R9 immediate code, both modes
        phase = "R9";
        prot_wr(8'h82);
        chk("R9", int'(wd_rst_req), 0);
        step();
        chk("R9", int'(wd_rst_req), 1);
        chk("R9", int'(ctl_rdata), 8'h14);
        prot_wr(8'h8A);
        step();
        chk("R9", int'(wd_rst_req), 1);
        chk("R9", int'(wd_irq), 0);

        // R10 reserved codes
        phase = "R10";
        prot_wr(8'h92);
        repeat (1200) step();
        chk("R10", int'(ctl_rdata), 8'h92);
        prot_wr(8'hFA);
        repeat (600) step();
        chk("R10", int'(ctl_rdata), 8'hFA);

        // R11 supply event disables and freezes
        phase = "R11";
        prot_wr(8'h02);
        repeat (300) step();
        psm_evt = 1'b1; step(); psm_evt = 1'b0;
        chk("R11", int'(ctl_rdata), 8'h00);
        repeat (600) step();
        chk("R11", int'(wd_rst_req), 0);
        prot_wr(8'h02);
        repeat (511) step();
        chk("R11", int'(wd_rst_req), 0);
        step();
        chk("R11", int'(wd_rst_req), 1);

        // R12 timeout in the commit cycle
        phase = "R12";
        prot_wr(8'h02);
        repeat (510) step();
        wr(8'h01);
        wr(8'hF2);
        chk("R12", int'(wd_rst_req), 1);
        chk("R12", int'(ctl_rdata), 8'h14);
        prot_wr(8'h0A);
        repeat (510) step();
        wr(8'h01);
        wr(8'h0A);
        chk("R12", int'(wd_irq), 1);
        chk("R12", int'(ctl_rdata), 8'h0E);

        repeat (4) step();
        finish_run();
    end

endmodule